// File: doc/BRIEF.md
# Byte-Count Driven I2C Master

This block is a register-programmed I2C bus master that runs a whole transaction by itself once software has set it up. Software loads a 7-bit target address, the number of data bytes minus one, an optional register-address byte and an SCL divider, then writes a command code that selects a write or a read. The controller generates START, sends the address byte with the direction bit, optionally sends the register-address byte (with a repeated START before a read), moves the data bytes through a one-byte transmit holding register or a one-byte receive holding register, and ends with STOP as soon as the counted bytes are done. Software only polls a status word and feeds or drains the holding registers.

The sequencer has six states. IDLE leaves both lines released and moves to START on an accepted command. START (also used for the repeated START) moves to SHIFT. SHIFT moves eight bits and then goes to ACK. ACK either returns to SHIFT (register-address byte after the address), returns to START (repeated START before a read), waits in HOLD for a data byte or for room in the receive register, or goes to STOP after the last counted byte or after a NACK from the target. HOLD keeps SCL low and moves to SHIFT once its holding register is ready. STOP returns to IDLE. Both bus lines are open-drain: the block only ever pulls them low.

Top module: `i2c_count_master`

## Requirements
- R1: After reset the status word (register 6) reads 0x2: busy (bit 0) clear, transmit-empty (bit 1) set, receive-ready (bit 2) clear, acknowledge-error (bit 3) clear; neither bus line is pulled low; the divider (register 3) reads its default of 250.
- R2: A write of a value above 127 to the target-address register (register 0) is rejected and the register keeps its previous value; values 0 to 127 are stored.
- R3: The count register (register 1) holds the number of data bytes minus one; a value of 0 moves exactly one data byte, and STOP follows the last counted byte without any software action.
- R4: Writing 1 to the command register (register 4) starts a write, writing 2 starts a read; any other code, and any command while busy, is ignored and leaves the bus untouched.
- R5: A write frame is START, the address byte {address, 0}, then the data bytes most significant bit first; transmit-empty is set whenever the transmit holding register (written at register 5) is free, and the controller holds SCL low until a byte is supplied.
- R6: During a read the controller acknowledges every received byte except the last counted one, which it answers with NACK before STOP; receive-ready is set while a byte waits in the receive register (read at register 5) and reading it clears the flag.
- R7: With the register-address phase enabled, a read frame is START, {address, 0}, the register-address byte, repeated START, {address, 1}, then the data bytes.
- R8: Configuration register 2 bit 0 set skips the register-address phase; when clear, the byte in bits 15:8 is sent right after the address byte of a write.
- R9: A NACK from the target on any byte the controller sends sets acknowledge-error, abandons the remaining bytes and issues STOP; the error stays set until the next accepted command clears it.
- R10: Each quarter of an SCL period lasts the divider value in system clocks, so SCL stays high for twice the divider value on every bit.
- R11: SDA changes only while SCL is low, except for the START and STOP conditions.
- R12: Busy is set from the cycle after an accepted command until STOP has completed, and only the end of STOP clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (takes the received byte at register 5) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid in the cycle of the read strobe |
| scl_low | output | 1 | Pull SCL low when high |
| sda_low | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The assertions watch, on every cycle, that SDA only moves while SCL is high inside START or STOP, that divider ticks never fall on adjacent cycles, that busy only drops at the end of STOP, that a NACK always leads straight into STOP and that no received byte overwrites one still waiting. The bench's scenarios are what show the frame contents: address and direction bit, register-address and repeated-START ordering, the count-minus-one length, the acknowledge pattern on reads, rejection of bad addresses and commands, the exact SCL high time and the sticky error clearing on the next command.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_SHIFT,
        S_ACK,
        S_HOLD,
        S_STOP
    } seq_state_t;

    typedef enum logic [2:0] {
        K_ADDR,
        K_REG,
        K_ADDR_RD,
        K_WDATA,
        K_RDATA
    } byte_kind_t;

    localparam logic [2:0] RA_TARGET = 3'd0;
    localparam logic [2:0] RA_COUNT  = 3'd1;
    localparam logic [2:0] RA_CONFIG = 3'd2;
    localparam logic [2:0] RA_DIVIDE = 3'd3;
    localparam logic [2:0] RA_CMD    = 3'd4;
    localparam logic [2:0] RA_DATA   = 3'd5;
    localparam logic [2:0] RA_STATUS = 3'd6;

    localparam int CMD_WRITE = 1;
    localparam int CMD_READ  = 2;
    localparam int ADDR_MAX  = 127;

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick = en && (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R10
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qtick,
    input  logic             go,
    input  logic             go_rd,
    input  logic             use_reg_in,
    input  logic [6:0]       dev,
    input  logic [7:0]       reg_byte,
    input  logic [CNT_W-1:0] count,
    input  logic             tx_full,
    input  logic [7:0]       tx_byte,
    input  logic             rx_full,
    input  logic             sda_in,
    output logic             busy,
    output logic             tick_en,
    output logic             tx_take,
    output logic             rx_put,
    output logic [7:0]       rx_byte,
    output logic             nack_seen,
    output logic             scl_lvl,
    output logic             sda_lvl
);

    seq_state_t       state;
    byte_kind_t       kind;
    logic [1:0]       q;
    logic [2:0]       bitcnt;
    logic [7:0]       sh;
    logic [CNT_W-1:0] left;
    logic             op_rd;
    logic             use_reg;
    logic             ack_smp;
    logic             end_bit;
    logic             sample;
    logic             is_rx;

    assign end_bit = qtick && (q == 2'd3);
    assign sample  = qtick && (q == 2'd2);
    assign is_rx   = (kind == K_RDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            kind    <= K_ADDR;
            q       <= 2'd0;
            bitcnt  <= 3'd0;
            sh      <= 8'd0;
            left    <= '0;
            op_rd   <= 1'b0;
            use_reg <= 1'b0;
            ack_smp <= 1'b0;
        end else begin
            if (qtick) q <= q + 2'd1;
            unique case (state)
                S_IDLE: if (go) begin
                    state   <= S_START;
                    q       <= 2'd0;
                    bitcnt  <= 3'd0;
                    op_rd   <= go_rd;
                    use_reg <= use_reg_in;
                    left    <= count;
                    sh      <= {dev, go_rd && !use_reg_in};
                    kind    <= (go_rd && !use_reg_in) ? K_ADDR_RD : K_ADDR;
                end
                S_START: if (end_bit) begin
                    state  <= S_SHIFT;
                    bitcnt <= 3'd0;
                end
                S_SHIFT: begin
                    if (sample && is_rx) sh <= {sh[6:0], sda_in};
                    if (end_bit) begin
                        if (!is_rx) sh <= {sh[6:0], 1'b0};
                        if (bitcnt == 3'd7) state <= S_ACK;
                        bitcnt <= bitcnt + 3'd1;
                    end
                end
                S_ACK: begin
                    if (sample) ack_smp <= sda_in;
                    if (end_bit) begin
                        if (is_rx) begin
                            if (left == '0) begin
                                state <= S_STOP;
                            end else begin
                                left  <= left - CNT_W'(1);
                                state <= S_HOLD;
                            end
                        end else if (ack_smp) begin
                            state <= S_STOP;
                        end else begin
                            unique case (kind)
                                K_ADDR: if (use_reg) begin
                                    sh    <= reg_byte;
                                    kind  <= K_REG;
                                    state <= S_SHIFT;
                                end else begin
                                    kind  <= K_WDATA;
                                    state <= S_HOLD;
                                end
                                K_REG: if (op_rd) begin
                                    sh    <= {dev, 1'b1};
                                    kind  <= K_ADDR_RD;
                                    state <= S_START;
                                end else begin
                                    kind  <= K_WDATA;
                                    state <= S_HOLD;
                                end
                                K_ADDR_RD: begin
                                    kind  <= K_RDATA;
                                    state <= S_HOLD;
                                end
                                default: if (left == '0) begin
                                    state <= S_STOP;
                                end else begin
                                    left  <= left - CNT_W'(1);
                                    state <= S_HOLD;
                                end
                            endcase
                        end
                    end
                end
                S_HOLD: begin
                    q <= 2'd0;
                    if (is_rx) begin
                        if (!rx_full) state <= S_SHIFT;
                    end else if (tx_full) begin
                        sh    <= tx_byte;
                        state <= S_SHIFT;
                    end
                end
                S_STOP: if (end_bit) state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        scl_lvl = 1'b1;
        sda_lvl = 1'b1;
        unique case (state)
            S_IDLE: begin
                scl_lvl = 1'b1;
                sda_lvl = 1'b1;
            end
            S_START: begin
                scl_lvl = (q == 2'd1) || (q == 2'd2);
                sda_lvl = (q <= 2'd1);
            end
            S_SHIFT: begin
                scl_lvl = (q == 2'd1) || (q == 2'd2);
                sda_lvl = is_rx ? 1'b1 : sh[7];
            end
            S_ACK: begin
                scl_lvl = (q == 2'd1) || (q == 2'd2);
                sda_lvl = is_rx ? (left == '0) : 1'b1;
            end
            S_HOLD: begin
                scl_lvl = 1'b0;
                sda_lvl = 1'b1;
            end
            S_STOP: begin
                scl_lvl = (q != 2'd0);
                sda_lvl = (q >= 2'd2);
            end
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign tick_en   = busy && (state != S_HOLD);
    assign tx_take   = (state == S_HOLD) && !is_rx && tx_full;
    assign rx_put    = (state == S_SHIFT) && is_rx && end_bit && (bitcnt == 3'd7);
    assign rx_byte   = sh;
    assign nack_seen = (state == S_ACK) && !is_rx && end_bit && ack_smp;

    // R11
    sda_while_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && (sda_lvl != $past(sda_lvl)))
            |-> (state == S_START || state == S_STOP));

    // R12
    busy_drop_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state) == S_STOP));

    // R9
    nack_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_seen |=> (state == S_STOP));

endmodule

// File: rtl/i2c_count_master.sv
module i2c_count_master
    import i2cm_pkg::*;
#(
    parameter int REG_W       = 16,
    parameter int CNT_W       = 8,
    parameter int DIV_W       = 16,
    parameter int DEFAULT_DIV = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             scl_low,
    output logic             sda_low,
    input  logic             sda_in
);

    logic [6:0]       tgt;
    logic [CNT_W-1:0] cnt;
    logic             skip_reg;
    logic [7:0]       reg_byte;
    logic [DIV_W-1:0] div;
    logic [7:0]       tx_hold;
    logic             tx_full;
    logic [7:0]       rx_hold;
    logic             rx_full;
    logic             ack_err;

    logic             busy, tick_en, qtick;
    logic             tx_take, rx_put, nack_seen;
    logic [7:0]       rx_byte;
    logic             scl_lvl, sda_lvl;
    logic             go, go_rd, cmd_wr;

    assign cmd_wr = reg_wr && (reg_addr == RA_CMD);
    assign go_rd  = (reg_wdata == REG_W'(CMD_READ));
    assign go     = cmd_wr && !busy && (go_rd || reg_wdata == REG_W'(CMD_WRITE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt      <= 7'd0;
            cnt      <= '0;
            skip_reg <= 1'b1;
            reg_byte <= 8'd0;
            div      <= DIV_W'(DEFAULT_DIV);
            tx_hold  <= 8'd0;
            tx_full  <= 1'b0;
            rx_hold  <= 8'd0;
            rx_full  <= 1'b0;
            ack_err  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_TARGET && reg_wdata <= REG_W'(ADDR_MAX))
                tgt <= reg_wdata[6:0];
            if (reg_wr && reg_addr == RA_COUNT)
                cnt <= reg_wdata[CNT_W-1:0];
            if (reg_wr && reg_addr == RA_CONFIG) begin
                skip_reg <= reg_wdata[0];
                reg_byte <= reg_wdata[15:8];
            end
            if (reg_wr && reg_addr == RA_DIVIDE)
                div <= reg_wdata[DIV_W-1:0];
            if (tx_take) tx_full <= 1'b0;
            if (reg_wr && reg_addr == RA_DATA) begin
                tx_hold <= reg_wdata[7:0];
                tx_full <= 1'b1;
            end
            if (reg_rd && reg_addr == RA_DATA) rx_full <= 1'b0;
            if (rx_put) begin
                rx_hold <= rx_byte;
                rx_full <= 1'b1;
            end
            if (nack_seen) ack_err <= 1'b1;
            if (go) begin
                tx_full <= 1'b0;
                rx_full <= 1'b0;
                ack_err <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_TARGET: reg_rdata[6:0] = tgt;
            RA_COUNT:  reg_rdata[CNT_W-1:0] = cnt;
            RA_CONFIG: begin
                reg_rdata[0]    = skip_reg;
                reg_rdata[15:8] = reg_byte;
            end
            RA_DIVIDE: reg_rdata[DIV_W-1:0] = div;
            RA_DATA:   reg_rdata[7:0] = rx_hold;
            RA_STATUS: reg_rdata[3:0] = {ack_err, rx_full, !tx_full, busy};
            default:   reg_rdata = '0;
        endcase
    end

    i2cm_qtick #(.DIV_W(DIV_W)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .div  (div),
        .tick (qtick)
    );

    i2cm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .qtick     (qtick),
        .go        (go),
        .go_rd     (go_rd),
        .use_reg_in(!skip_reg),
        .dev       (tgt),
        .reg_byte  (reg_byte),
        .count     (cnt),
        .tx_full   (tx_full),
        .tx_byte   (tx_hold),
        .rx_full   (rx_full),
        .sda_in    (sda_in),
        .busy      (busy),
        .tick_en   (tick_en),
        .tx_take   (tx_take),
        .rx_put    (rx_put),
        .rx_byte   (rx_byte),
        .nack_seen (nack_seen),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            scl_low <= !scl_lvl;
            sda_low <= !sda_lvl;
        end
    end

    // R6
    rx_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_put |-> !rx_full);

endmodule

// File: tb/i2c_count_master_tb.sv
`timescale 1ns/1ps
module i2c_count_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        m_scl_low, m_sda_low;
    logic        s_low = 1'b0;
    wire         scl_w = !m_scl_low;
    wire         sda_w = !(m_sda_low || s_low);

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 0;

    int ev_q[$];
    int mack_q[$];
    int rdata_q[$];
    int exp_q[$];
    int got_q[$];
    int nack_idx = -1;

    always #2 clk = !clk;

    i2c_count_master u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .scl_low  (m_scl_low),
        .sda_low  (m_sda_low),
        .sda_in   (sda_w)
    );

    // Behavioural bus observer and target: sees START/STOP/bytes, answers ACK, serves read bytes
    int       bitn = 0, bidx = 0, hi_cnt = 0, last_hi = 0;
    bit       rdm = 0, mnack = 0;
    logic [7:0] sh = 8'd0, cur = 8'hFF;
    logic     scl_p = 1'b1, sda_p = 1'b1;

    always @(negedge clk) begin
        logic sc, sd;
        bit   msend;
        sc = scl_w;
        sd = sda_w;
        if (rst_n) begin
            if (scl_p && sc && sda_p && !sd) begin
                ev_q.push_back(-1);
                bitn = 0; bidx = 0; rdm = 0; mnack = 0; s_low = 1'b0;
            end else if (scl_p && sc && !sda_p && sd) begin
                ev_q.push_back(-2);
                bitn = 0; bidx = 0; rdm = 0; s_low = 1'b0;
            end else if (!scl_p && sc) begin
                hi_cnt = 1;
                if (bitn < 8) begin
                    sh = {sh[6:0], sd};
                end else if (bidx > 0 && rdm) begin
                    mack_q.push_back(int'(sd));
                    if (sd) mnack = 1;
                end
                if (bitn == 7) begin
                    ev_q.push_back(int'(sh));
                    if (bidx == 0) rdm = sh[0];
                end
                bitn++;
                if (bitn == 9) begin
                    bitn = 0;
                    bidx++;
                end
            end else if (scl_p && !sc) begin
                last_hi = hi_cnt;
                msend = !(bidx > 0 && rdm);
                if (bitn == 8) begin
                    s_low = msend && (bidx != nack_idx);
                end else if (!msend && !mnack) begin
                    if (bitn == 0) cur = (rdata_q.size() > 0) ? 8'(rdata_q.pop_front()) : 8'hFF;
                    s_low = !cur[7 - bitn];
                end else begin
                    s_low = 1'b0;
                end
            end else if (sc) begin
                hi_cnt++;
            end
            scl_p = sc;
            sda_p = sd;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_frame(input string req);
        n_checks++;
        if (ev_q.size() != exp_q.size()) begin
            n_errors++;
            $display("FAIL %s: actual %0d bus events expected %0d", req, ev_q.size(), exp_q.size());
        end else begin
            foreach (exp_q[i]) begin
                if (ev_q[i] != exp_q[i]) begin
                    n_errors++;
                    $display("FAIL %s: event %0d actual %0d expected %0d", req, i, ev_q[i], exp_q[i]);
                    break;
                end
            end
        end
        ev_q.delete();
        exp_q.delete();
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic launch(input int a, input int n, input int cmd, output logic [15:0] st);
        reg_write(3'd0, 16'(a));
        reg_write(3'd1, 16'(n - 1));
        reg_write(3'd4, 16'(cmd));
        reg_read(3'd6, st);
    endtask

    task automatic wait_idle();
        logic [15:0] st;
        for (int k = 0; k < 20000; k++) begin
            reg_read(3'd6, st);
            if (!st[0]) break;
        end
    endtask

    task automatic do_write(input int a, input int n, input int bytes[$], output logic [15:0] st0);
        logic [15:0] st;
        int idx;
        idx = 0;
        launch(a, n, 1, st0);
        for (int k = 0; k < 20000 && idx < bytes.size(); k++) begin
            reg_read(3'd6, st);
            if (!st[0]) break;
            if (st[1]) begin
                reg_write(3'd5, 16'(bytes[idx]));
                idx++;
            end
        end
        wait_idle();
    endtask

    task automatic do_read(input int a, input int n, output logic [15:0] st0);
        logic [15:0] st, d;
        launch(a, n, 2, st0);
        for (int k = 0; k < 20000; k++) begin
            reg_read(3'd6, st);
            if (st[2]) begin
                reg_read(3'd5, d);
                got_q.push_back(int'(d[7:0]));
            end else if (!st[0]) begin
                break;
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] st, d;
        int wb[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(3'd6, st);
        chk("R1 status", int'(st), 32'h2);
        chk("R1 scl released", int'(m_scl_low), 0);
        chk("R1 sda released", int'(m_sda_low), 0);
        reg_read(3'd3, d);
        chk("R1 divider default", int'(d), 250);

        // R2 address range
        reg_write(3'd0, 16'h0050);
        reg_write(3'd0, 16'h00C5);
        reg_read(3'd0, d);
        chk("R2 out-of-range address rejected", int'(d), 32'h50);

        reg_write(3'd3, 16'd3);
        reg_write(3'd2, 16'h0001);

        // R3 R5 R8 write of three bytes, register phase skipped; R4 command while busy ignored
        wb = '{8'hA5, 8'h3C, 8'h81};
        launch(8'h50, 3, 1, st);
        chk("R12 busy right after command", int'(st[0]), 1);
        reg_write(3'd4, 16'd2);
        for (int k = 0; k < 20000 && wb.size() > 0; k++) begin
            reg_read(3'd6, st);
            if (st[1]) reg_write(3'd5, 16'(wb.pop_front()));
        end
        wait_idle();
        exp_q = '{-1, 8'hA0, 8'hA5, 8'h3C, 8'h81, -2};
        chk_frame("R3 R4 R5 R11 write frame");
        reg_read(3'd6, st);
        chk("R3 idle after automatic stop", int'(st[3:0]), 32'h2);
        chk("R10 scl high time div=3", last_hi, 6);

        // R9 target NACKs the second data byte
        nack_idx = 2;
        do_write(8'h50, 4, '{8'h11, 8'h22, 8'h33, 8'h44}, st);
        nack_idx = -1;
        exp_q = '{-1, 8'hA0, 8'h11, 8'h22, -2};
        chk_frame("R9 abandoned frame");
        reg_read(3'd6, st);
        chk("R9 error set, not busy", int'(st & 16'h9), 32'h8);
        repeat (100) @(negedge clk);
        reg_read(3'd6, st);
        chk("R9 error sticky", int'(st[3]), 1);

        // R6 read of two bytes, no register phase
        rdata_q = '{8'h9E, 8'h47};
        mack_q.delete();
        got_q.delete();
        do_read(8'h21, 2, st);
        chk("R9 error cleared by next command", int'(st[3]), 0);
        exp_q = '{-1, 8'h43, 8'h9E, 8'h47, -2};
        chk_frame("R6 read frame");
        chk("R6 byte count", got_q.size(), 2);
        if (got_q.size() == 2) begin
            chk("R6 first byte", got_q[0], 8'h9E);
            chk("R6 second byte", got_q[1], 8'h47);
        end
        chk("R6 ack pattern size", mack_q.size(), 2);
        if (mack_q.size() == 2) begin
            chk("R6 ack on first", mack_q[0], 0);
            chk("R6 nack on last", mack_q[1], 1);
        end
        reg_read(3'd6, st);
        chk("R6 receive-ready cleared", int'(st[2]), 0);

        // R7 read with register phase and repeated START, count 0 -> one byte
        reg_write(3'd2, 16'h1F00);
        rdata_q = '{8'h6B};
        mack_q.delete();
        got_q.delete();
        do_read(8'h21, 1, st);
        exp_q = '{-1, 8'h42, 8'h1F, -1, 8'h43, 8'h6B, -2};
        chk_frame("R7 R3 combined read frame");
        chk("R7 one byte read", got_q.size(), 1);
        if (got_q.size() == 1) chk("R7 byte value", got_q[0], 8'h6B);
        chk("R7 nack on single byte", (mack_q.size() == 1) ? mack_q[0] : -1, 1);

        // R8 write with register phase
        reg_write(3'd2, 16'h0700);
        do_write(8'h50, 1, '{8'hEE}, st);
        exp_q = '{-1, 8'hA0, 8'h07, 8'hEE, -2};
        chk_frame("R8 register phase on write");

        // R4 unknown command code
        reg_write(3'd4, 16'd3);
        repeat (200) @(negedge clk);
        chk("R4 no bus activity", ev_q.size(), 0);
        reg_read(3'd6, st);
        chk("R4 not busy", int'(st[0]), 0);

        // R10 different divider
        reg_write(3'd2, 16'h0001);
        reg_write(3'd3, 16'd5);
        do_write(8'h3A, 1, '{8'h5A}, st);
        exp_q = '{-1, 8'h74, 8'h5A, -2};
        chk_frame("R10 frame at div=5");
        chk("R10 scl high time div=5", last_hi, 10);

        finish_run();
    end

endmodule